// File: doc/BRIEF.md
# Converter Output Stage

This block sits between a 10-bit converter core and the chip's parallel data pins. Each converter word arrives with a valid bit. The block captures the word on a chosen edge of the converter clock and passes it through a register pipeline whose depth depends on the selected signal path. It then launches the word onto the output bus on the selected edge of either the converter clock or a separate external output clock. A valid flag travels through the same registers, so it always marks the word it belongs to.

The block runs on one fast system clock. The converter clock and the external output clock enter as sampled signals. A small control unit turns their transitions into single-cycle strobes. The datapath acts only on those strobes.

Configuration bits select:
- the output clock source,
- the output edge,
- the capture edge,
- the path code.

A separate output-enable tells the pad drivers when to float the bus. It drops for any one of three conditions: an output-disable bit, a power-down bit, or the active-low standby pin.

Top module: `adc_out_stage`

## Requirements
- R1: The word is passed unchanged in straight binary, with bit 9 as the MSB. An all-zero input word reaches the bus as 10'h000 and an all-one word as 10'h3FF.
- R2: With `srcSel`=0, `dataOut` and `dataValid` change only in system cycles in which the converter clock shows the selected edge.
- R3: With `srcSel`=1, `dataOut` and `dataValid` change only on the selected edge of `extClk`, independent of converter clock edges.
- R4: `edgeSel`=0 launches on the rising edge of the chosen output clock. `edgeSel`=1 launches on the falling edge.
- R5: With `clkInv`=0, the word is captured on the converter clock falling edge. It is loaded onto the bus by the 6th rising edge after capture, when the converter clock is the output clock on its rising edge. This is a latency of 5.5 converter periods.
- R6: With `clkInv`=1, the word is captured on the converter clock rising edge. It is loaded by the 6th later rising edge, a latency of 6.0 periods.
- R7: Path code `pathSel`=2'b01 adds two converter-clock periods of latency. Codes 2'b00, 2'b10 and 2'b11 use the base latency.
- R8: `dataOe` is low one system cycle after any of these is sampled: `standbyN`=0, `powerDown`=1 or `outDisable`=1.
- R9: `dataOe` is high one system cycle after `standbyN`=1, `powerDown`=0 and `outDisable`=0 are all sampled.
- R10: The pipeline and output register keep running while the enable is low, so the bus word is current as soon as the enable returns.
- R11: During reset, `dataOut`=0, `dataValid`=0 and `dataOe`=0. `dataValid` is always the valid bit captured with the word on `dataOut`, independent of `dataOe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all other inputs |
| rstN | input | 1 | Asynchronous active-low reset |
| adcClk | input | 1 | Converter clock, sampled as a signal |
| extClk | input | 1 | External output clock, sampled as a signal |
| wordIn | input | 10 | Raw converter word, straight binary |
| wordValid | input | 1 | Valid bit for `wordIn` |
| srcSel | input | 1 | Output clock source: 0 converter clock, 1 external clock |
| edgeSel | input | 1 | Output edge: 0 rising, 1 falling |
| clkInv | input | 1 | Capture edge: 0 falling, 1 rising converter edge |
| pathSel | input | 2 | Signal path code; 2'b01 selects the longer pipeline |
| outDisable | input | 1 | Forces the bus to float when 1 |
| powerDown | input | 1 | Forces the bus to float when 1 |
| standbyN | input | 1 | Standby pin, active low; forces the bus to float when 0 |
| dataOut | output | 10 | Output bus word |
| dataOe | output | 1 | Drive enable for the bus pads |
| dataValid | output | 1 | Valid flag aligned with `dataOut` |

## Verification
Two events can coincide in one system cycle.

The first case is inverted capture. The capture strobe and the pipeline shift both come from the same rising converter edge. A new word enters stage 0 while the previous word moves to stage 1.

The second case is the converter clock on its rising edge as the output clock. The launch and the shift then share one cycle, and the output must take the tail word as it stood before the shift.

Both cases are provoked by segments that use inverted capture, the converter clock as source, or both, with every path code. They are judged by a bench model. The model evaluates the launch before it counts the rising edge, and counts the edge before it stores a new capture. It is compared against the bus in every system cycle.

// File: rtl/adc_out_pkg.sv
package adc_out_pkg;

  // Single-cycle events the control unit hands to the datapath
  typedef struct packed {
    logic capture;   // load stage 0 from the converter word
    logic shift;     // advance the pipeline one stage
    logic launch;    // load the output register from the tail
    logic longPath;  // use the deeper tail tap
  } outStrobes_t;

endpackage

// File: rtl/adc_out_ctrl.sv
module adc_out_ctrl
  import adc_out_pkg::*;
#(
  parameter int PATH_W = 2,
  parameter logic [PATH_W-1:0] LONG_CODE = PATH_W'(1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adcClk,
  input  logic              extClk,
  input  logic              srcSel,
  input  logic              edgeSel,
  input  logic              clkInv,
  input  logic [PATH_W-1:0] pathSel,
  input  logic              outDisable,
  input  logic              powerDown,
  input  logic              standbyN,
  output outStrobes_t       stb,
  output logic              oeQ
);

  logic adcPrev, extPrev;
  logic adcRise, adcFall, extRise, extFall;
  logic srcRise, srcFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adcPrev <= 1'b0;
      extPrev <= 1'b0;
      oeQ     <= 1'b0;
    end else begin
      adcPrev <= adcClk;
      extPrev <= extClk;
      oeQ     <= standbyN & ~powerDown & ~outDisable;
    end
  end

  always_comb begin
    adcRise = adcClk & ~adcPrev;
    adcFall = ~adcClk & adcPrev;
    extRise = extClk & ~extPrev;
    extFall = ~extClk & extPrev;
    srcRise = srcSel ? extRise : adcRise;
    srcFall = srcSel ? extFall : adcFall;

    stb.launch   = edgeSel ? srcFall : srcRise;
    // capture on the edge opposite the shift edge gives the half period
    stb.capture  = clkInv ? adcRise : adcFall;
    stb.shift    = adcRise;
    stb.longPath = (pathSel == LONG_CODE);
  end

  AST_STBY_FLOATS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !standbyN |=> !oeQ); // R8
  AST_PDN_FLOATS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> !oeQ); // R8
  AST_DIS_FLOATS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    outDisable |=> !oeQ); // R8
  AST_CLEAR_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (standbyN && !powerDown && !outDisable) |=> oeQ); // R9

endmodule

// File: rtl/adc_out_dpath.sv
module adc_out_dpath
  import adc_out_pkg::*;
#(
  parameter int WORD_W    = 10,
  parameter int BASE_LAT  = 6,
  parameter int EXTRA_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  outStrobes_t       stb,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              wordValid,
  output logic [WORD_W-1:0] outWord,
  output logic              outValid
);

  // Stage 0 plus (tail index) shifting stages; the output register is the last hop
  localparam int SHORT_TAIL = BASE_LAT - 1;
  localparam int LONG_TAIL  = BASE_LAT + EXTRA_LAT - 1;
  localparam int DEPTH      = LONG_TAIL + 1;

  logic [WORD_W-1:0] stWord [DEPTH];
  logic [DEPTH-1:0]  stValid;
  logic [WORD_W-1:0] tailWord;
  logic              tailValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) stWord[i] <= '0;
      stValid  <= '0;
      outWord  <= '0;
      outValid <= 1'b0;
    end else begin
      if (stb.shift) begin
        for (int i = 1; i < DEPTH; i++) begin
          stWord[i]  <= stWord[i-1];
          stValid[i] <= stValid[i-1];
        end
      end
      if (stb.capture) begin
        stWord[0]  <= wordIn;
        stValid[0] <= wordValid;
      end
      if (stb.launch) begin
        outWord  <= tailWord;
        outValid <= tailValid;
      end
    end
  end

  generate
    if (EXTRA_LAT > 0) begin : g_tapMux
      always_comb begin
        tailWord  = stb.longPath ? stWord[LONG_TAIL]  : stWord[SHORT_TAIL];
        tailValid = stb.longPath ? stValid[LONG_TAIL] : stValid[SHORT_TAIL];
      end
    end else begin : g_tapFixed
      always_comb begin
        tailWord  = stWord[SHORT_TAIL];
        tailValid = stValid[SHORT_TAIL];
      end
    end
  endgenerate

  AST_HOLD_BETWEEN_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    !stb.launch |=> ($stable(outWord) && $stable(outValid))); // R2
  AST_CAPTURE_TAKES_WORD: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (stWord[0] == $past(wordIn) && stValid[0] == $past(wordValid))); // R11

endmodule

// File: rtl/adc_out_stage.sv
module adc_out_stage
  import adc_out_pkg::*;
#(
  parameter int WORD_W    = 10,
  parameter int BASE_LAT  = 6,
  parameter int EXTRA_LAT = 2,
  parameter int PATH_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adcClk,
  input  logic              extClk,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              wordValid,
  input  logic              srcSel,
  input  logic              edgeSel,
  input  logic              clkInv,
  input  logic [PATH_W-1:0] pathSel,
  input  logic              outDisable,
  input  logic              powerDown,
  input  logic              standbyN,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataOe,
  output logic              dataValid
);

  outStrobes_t stb;

  adc_out_ctrl #(
    .PATH_W    (PATH_W),
    .LONG_CODE (PATH_W'(1))
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .adcClk     (adcClk),
    .extClk     (extClk),
    .srcSel     (srcSel),
    .edgeSel    (edgeSel),
    .clkInv     (clkInv),
    .pathSel    (pathSel),
    .outDisable (outDisable),
    .powerDown  (powerDown),
    .standbyN   (standbyN),
    .stb        (stb),
    .oeQ        (dataOe)
  );

  adc_out_dpath #(
    .WORD_W    (WORD_W),
    .BASE_LAT  (BASE_LAT),
    .EXTRA_LAT (EXTRA_LAT)
  ) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wordIn    (wordIn),
    .wordValid (wordValid),
    .outWord   (dataOut),
    .outValid  (dataValid)
  );

endmodule

// File: tb/test_adc_out_stage.sv
`timescale 1ns/1ps
module test_adc_out_stage;

  localparam int W       = 10;
  localparam int SEG_CYC = 300;
  localparam int HIST    = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic adcClk = 1'b0, extClk = 1'b0;
  logic [W-1:0] wordIn = '0;
  logic wordValid = 1'b0;
  logic srcSel = 1'b0, edgeSel = 1'b0, clkInv = 1'b0;
  logic [1:0] pathSel = 2'b00;
  logic outDisable = 1'b0, powerDown = 1'b0, standbyN = 1'b1;
  logic [W-1:0] dataOut;
  logic dataOe, dataValid;

  always #2.5 clk = ~clk;

  adc_out_stage i_adc_out_stage (
    .clk(clk), .rstN(rstN), .adcClk(adcClk), .extClk(extClk),
    .wordIn(wordIn), .wordValid(wordValid), .srcSel(srcSel), .edgeSel(edgeSel),
    .clkInv(clkInv), .pathSel(pathSel), .outDisable(outDisable),
    .powerDown(powerDown), .standbyN(standbyN),
    .dataOut(dataOut), .dataOe(dataOe), .dataValid(dataValid)
  );

  int nChk = 0, nBad = 0;
  string curTag = "R5";
  int adcCnt = 0, extCnt = 0, extPer = 6, dirIdx = 0, oeMode = 0, dMode = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: word history with converter rising edges seen since capture
  logic [W-1:0] hW [HIST];
  logic         hV [HIST];
  int           hR [HIST];
  int  hN = 0;
  logic [W-1:0] expD = '0;
  logic expV = 1'b0, expOe = 1'b0, pa = 1'b0, pe = 1'b0;
  bit live = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      hN = 0; expD = '0; expV = 1'b0; expOe = 1'b0; pa = 1'b0; pe = 1'b0; live = 0;
    end else begin
      logic aR, aF, eR, eF, cap, lau;
      int tailIdx;
      bit found;
      aR = adcClk & ~pa;  aF = ~adcClk & pa;
      eR = extClk & ~pe;  eF = ~extClk & pe;
      cap = clkInv ? aR : aF;
      lau = srcSel ? (edgeSel ? eF : eR) : (edgeSel ? aF : aR);
      tailIdx = (pathSel == 2'b01) ? 7 : 5;
      if (lau) begin
        found = 0;
        for (int i = 0; i < hN; i++)
          if (!found && hR[i] >= tailIdx) begin
            expD = hW[i]; expV = hV[i]; found = 1;
          end
        if (!found) begin expD = '0; expV = 1'b0; end
      end
      if (aR) for (int i = 0; i < hN; i++) if (hR[i] < 100) hR[i]++;
      if (cap) begin
        for (int i = HIST-1; i > 0; i--) begin
          hW[i] = hW[i-1]; hV[i] = hV[i-1]; hR[i] = hR[i-1];
        end
        hW[0] = wordIn; hV[0] = wordValid; hR[0] = 0;
        if (hN < HIST) hN++;
      end
      expOe = standbyN & ~powerDown & ~outDisable;
      pa = adcClk; pe = extClk;
      live = 1;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rstN && live && !done) begin
      chk(curTag, int'(dataOut), int'(expD));
      chk("R11", int'(dataValid), int'(expV));
      chk(expOe ? "R9" : "R8", int'(dataOe), int'(expOe));
    end
  end

  task automatic newWord();
    if (dMode == 0) begin
      wordIn = W'($urandom_range(0, (1 << W) - 1));
      wordValid = ($urandom_range(0, 4) != 0);
    end else begin
      case (dirIdx % 4)
        0: wordIn = '0;
        1: wordIn = '1;
        2: wordIn = W'(1 << ((dirIdx / 4) % W));
        default: wordIn = ~W'(1 << ((dirIdx / 4) % W));
      endcase
      wordValid = 1'b1;
      dirIdx++;
    end
  endtask

  task automatic step();
    adcCnt = (adcCnt + 1) % 8;
    adcClk = (adcCnt >= 4);
    extCnt = (extCnt + 1) % extPer;
    extClk = (extCnt >= extPer / 2);
    // change the word half a period away from its capture edge
    if ((!clkInv && adcCnt == 4) || (clkInv && adcCnt == 0)) newWord();
    if (oeMode != 0 && $urandom_range(0, 11) == 0) begin
      case ($urandom_range(0, 2))
        0: standbyN = ~standbyN;
        1: powerDown = ~powerDown;
        default: outDisable = ~outDisable;
      endcase
    end
  endtask

  task automatic runSeg(input logic s, input logic e, input logic inv, input logic [1:0] p,
                        input int oeM, input int dM, input string tag);
    @(negedge clk);
    rstN = 1'b0; adcClk = 1'b0; extClk = 1'b0; adcCnt = 0; extCnt = 0;
    srcSel = s; edgeSel = e; clkInv = inv; pathSel = p;
    standbyN = 1'b1; powerDown = 1'b0; outDisable = 1'b0;
    oeMode = oeM; dMode = dM; curTag = tag;
    extPer = 5 + $urandom_range(0, 4);
    @(posedge clk); #1;
    chk("R11", int'(dataOut), 0);
    chk("R11", int'(dataValid), 0);
    chk("R11", int'(dataOe), 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (SEG_CYC) begin
      @(negedge clk);
      step();
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    runSeg(0, 0, 0, 2'b00, 0, 0, "R5");
    runSeg(0, 0, 0, 2'b00, 0, 1, "R1");
    runSeg(0, 1, 1, 2'b10, 0, 1, "R1");
    runSeg(0, 1, 0, 2'b00, 0, 0, "R4");
    runSeg(0, 0, 1, 2'b00, 0, 0, "R6");
    runSeg(0, 0, 0, 2'b01, 0, 0, "R7");
    runSeg(0, 1, 1, 2'b01, 0, 0, "R7");
    runSeg(0, 0, 1, 2'b11, 0, 0, "R2");
    runSeg(0, 1, 0, 2'b10, 0, 0, "R2");
    runSeg(1, 0, 0, 2'b00, 0, 0, "R3");
    runSeg(1, 1, 1, 2'b01, 0, 0, "R3");
    runSeg(0, 0, 0, 2'b00, 1, 0, "R10");
    runSeg(1, 1, 0, 2'b01, 1, 0, "R10");
    for (int k = 0; k < 6; k++) begin
      logic rs;
      rs = 1'($urandom_range(0, 1));
      runSeg(rs, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             2'($urandom_range(0, 3)), int'($urandom_range(0, 1)), 0, rs ? "R3" : "R2");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChk++; nBad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule